// File: doc/BRIEF.md
# Interrupt Acknowledge Cycle Sequencer

This block runs the bus cycles a processor core needs once it has decided to take a general-purpose interrupt. A one-clock acceptance pulse starts a sequence. The response mode in force at that moment decides what the sequence does. In fetch mode (mode 0) the block collects an instruction from the interrupting peripheral, one byte per acknowledge strobe. It works out from the opcode how many bytes to gather and whether the return address must be saved. In fixed mode (mode 1) it skips the bus altogether and reports a constant restart address. In table mode (mode 2) it takes one byte from the device under an acknowledge strobe. It joins that byte with the core's 8-bit base register to form a pointer into a table of service addresses. It then asks for the return address to be pushed and reads two bytes from the table.

When a sequence ends, the block raises `done` for one clock. In that clock it presents the 16-bit jump target and a flag that says whether the program counter has to be pushed. Decoding the fetched instruction beyond the length classifier, and the stack write itself, belong to the surrounding core.

Top module: `intack_seq`

## Requirements
- R1: While reset is asserted and in the first clock after it is released, `ack`, `wait_ins`, `rd_strb`, `push_pc` and `done` are all 0. The response mode after reset is fetch mode (0).
- R2: A clock with `mode_wr` high loads `mode_val` into the mode register when the value is 0, 1 or 2. A write of 3 is ignored, and the mode held before stays in force. The mode is captured when a sequence is accepted.
- R3: In fetch mode the first acknowledge strobe lasts at least three clocks, and `wait_ins` is high during its first two. Each later strobe lasts one clock and has no inserted waits. `ack` drops for exactly one clock between strobes.
- R4: A fetched opcode whose bits [7:6] are 11 and bits [2:0] are 111 is a one-byte restart. The sequence ends after one strobe with target = {8'h00, opcode & 8'h38} and the push flag set.
- R5: Opcode 8'hCD is a three-byte call. Three strobes are made, the target is {third byte, second byte}, and the push flag is set.
- R6: Opcode 8'hC3 is a three-byte jump. Three strobes are made, the target is {third byte, second byte}, and the push flag is clear.
- R7: Any other opcode ends the sequence after one strobe, with target 16'h0000 and the push flag clear.
- R8: Fixed mode makes no acknowledge or table-read strobe. `done` is high in the clock right after acceptance, with target 16'h0038 and the push flag set.
- R9: Table mode makes one acknowledge strobe with no inserted waits, and takes the device byte from it. `push_pc` then pulses for one clock. Two table reads follow, at {base, device byte with bit 0 cleared} and then at that address with bit 0 set. The first byte read forms target[7:0] and the second forms target[15:8]. The push flag is set.
- R10: Once the inserted waits of a strobe have elapsed, each clock in which `ext_wait` is high lengthens an acknowledge or table-read strobe by one clock. The read address stays unchanged during the extension. The byte is taken in the clock where `ext_wait` is low.
- R11: `done` is high for exactly one clock per sequence, and no strobe is active during it. Outside that clock, `target` is 0 and `push_flag` is 0.
- R12: A `req` pulse that arrives while a sequence is running is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_wr | input | 1 | Mode register write enable |
| mode_val | input | 2 | Mode value to write (0, 1 or 2) |
| req | input | 1 | One-clock acceptance pulse that starts a sequence |
| base_reg | input | 8 | Upper byte of the table-mode pointer |
| din | input | 8 | Data bus input |
| ext_wait | input | 1 | External wait request |
| ack | output | 1 | Interrupt acknowledge strobe |
| wait_ins | output | 1 | High during an inserted wait state |
| rd_strb | output | 1 | Table read strobe |
| rd_addr | output | 16 | Table read address, 0 when no read strobe is active |
| push_pc | output | 1 | One-clock request to push the program counter (table mode) |
| done | output | 1 | One-clock end-of-sequence pulse |
| target | output | 16 | Jump target, valid while `done` is high |
| push_flag | output | 1 | Push-needed flag, valid while `done` is high |

## Verification
The bench measures the length of every strobe. A design that inserted waits on every fetch strobe, or on the table-mode strobe, would lengthen the call and vector sequences beyond one clock per later strobe. Operand order is checked with unequal bytes, so a swapped high/low assembly gives the wrong call, jump or table target. A table read whose pointer keeps the device's bit 0 gives an odd first address. Two further cases are covered: a second `req` in mid-sequence, which a design that restarted would answer with a second `done`, and a write of the unused mode code, which a design without the guard would take as a mode change.

// File: rtl/intack_pkg.sv
package intack_pkg;

    typedef enum logic [1:0] {
        IM_FETCH = 2'd0,
        IM_FIXED = 2'd1,
        IM_TABLE = 2'd2
    } im_mode_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ACK,
        S_GAP,
        S_PUSH,
        S_RD,
        S_DONE
    } seq_state_e;

    typedef enum logic [1:0] {
        K_OTHER,
        K_RST,
        K_CALL,
        K_JMP
    } op_kind_e;

    localparam int LEN_W = 3;

    typedef struct packed {
        op_kind_e           kind;
        logic [LEN_W-1:0]   len;
        logic               push;
    } op_info_t;

    function automatic op_info_t classify(input logic [7:0] op);
        op_info_t r;
        if (op[7:6] == 2'b11 && op[2:0] == 3'b111) begin
            r = '{kind: K_RST, len: LEN_W'(1), push: 1'b1};
        end else if (op == 8'hCD) begin
            r = '{kind: K_CALL, len: LEN_W'(3), push: 1'b1};
        end else if (op == 8'hC3) begin
            r = '{kind: K_JMP, len: LEN_W'(3), push: 1'b0};
        end else begin
            r = '{kind: K_OTHER, len: LEN_W'(1), push: 1'b0};
        end
        return r;
    endfunction

endpackage

// File: rtl/intack_mode_reg.sv
module intack_mode_reg
    import intack_pkg::*;
#(
    parameter im_mode_e RESET_MODE = IM_FETCH
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr,
    input  logic [1:0] val,
    output im_mode_e   mode
);
    im_mode_e mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= RESET_MODE;
        end else if (wr && val != 2'd3) begin
            mode_q <= im_mode_e'(val);
        end
    end

    assign mode = mode_q;
endmodule

// File: rtl/intack_cyc_timer.sv
module intack_cyc_timer #(
    parameter int WAIT_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WAIT_W-1:0] load_val,
    input  logic              in_cycle,
    input  logic              ext_wait,
    output logic              wait_ins,
    output logic              ready
);
    logic [WAIT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (in_cycle && cnt_q != '0) begin
            cnt_q <= cnt_q - WAIT_W'(1);
        end
    end

    assign wait_ins = in_cycle && (cnt_q != '0);
    assign ready    = in_cycle && (cnt_q == '0) && !ext_wait;
endmodule

// File: rtl/intack_seq.sv
module intack_seq
    import intack_pkg::*;
#(
    parameter int          FIRST_WAITS = 2,
    parameter logic [15:0] FIXED_ADDR  = 16'h0038,
    parameter int          OPND_BYTES  = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        mode_wr,
    input  logic [1:0]  mode_val,
    input  logic        req,
    input  logic [7:0]  base_reg,
    input  logic [7:0]  din,
    input  logic        ext_wait,
    output logic        ack,
    output logic        wait_ins,
    output logic        rd_strb,
    output logic [15:0] rd_addr,
    output logic        push_pc,
    output logic        done,
    output logic [15:0] target,
    output logic        push_flag
);
    localparam int WAIT_W = (FIRST_WAITS < 1) ? 1 : $clog2(FIRST_WAITS + 1);

    seq_state_e        st_q, st_d;
    im_mode_e          mode_now, mode_cur;
    logic [LEN_W-1:0]  idx_q, len_q;
    op_kind_e          kind_q;
    logic              push_q;
    logic [2:0]        rvec_q;
    logic [7:0]        opnd_q [OPND_BYTES];
    logic [7:0]        vec_hi_q, vec_lo_q, tlo_q, thi_q;
    logic              rd_sel_q;
    logic              tmr_load, in_cyc, ready;
    logic [WAIT_W-1:0] tmr_val;
    logic              take_ack, take_rd, last_byte;
    op_info_t          info;

    intack_mode_reg #(.RESET_MODE(IM_FETCH)) u_mode (
        .clk  (clk),
        .rst  (rst),
        .wr   (mode_wr),
        .val  (mode_val),
        .mode (mode_now)
    );

    intack_cyc_timer #(.WAIT_W(WAIT_W)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .in_cycle (in_cyc),
        .ext_wait (ext_wait),
        .wait_ins (wait_ins),
        .ready    (ready)
    );

    assign info     = classify(din);
    assign in_cyc   = (st_q == S_ACK) || (st_q == S_RD);
    assign take_ack = (st_q == S_ACK) && ready;
    assign take_rd  = (st_q == S_RD) && ready;
    assign last_byte = (idx_q == '0) ? (info.len == LEN_W'(1))
                                     : (idx_q + LEN_W'(1) == len_q);

    // sequencing
    always_comb begin
        st_d     = st_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (st_q)
            S_IDLE: if (req) begin
                unique case (mode_now)
                    IM_FIXED: st_d = S_DONE;
                    IM_TABLE: begin st_d = S_ACK; tmr_load = 1'b1; end
                    default: begin
                        st_d     = S_ACK;
                        tmr_load = 1'b1;
                        tmr_val  = WAIT_W'(FIRST_WAITS);
                    end
                endcase
            end
            S_ACK: if (ready) begin
                if (mode_cur == IM_TABLE) st_d = S_PUSH;
                else                      st_d = last_byte ? S_DONE : S_GAP;
            end
            S_GAP: begin
                st_d     = (mode_cur == IM_TABLE) ? S_RD : S_ACK;
                tmr_load = 1'b1;
            end
            S_PUSH: begin
                st_d     = S_RD;
                tmr_load = 1'b1;
            end
            S_RD: if (ready) st_d = rd_sel_q ? S_DONE : S_GAP;
            S_DONE: st_d = S_IDLE;
            default: st_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= S_IDLE;
            mode_cur <= IM_FETCH;
            idx_q    <= '0;
            len_q    <= LEN_W'(1);
            kind_q   <= K_OTHER;
            push_q   <= 1'b0;
            rvec_q   <= '0;
            vec_hi_q <= '0;
            vec_lo_q <= '0;
            tlo_q    <= '0;
            thi_q    <= '0;
            rd_sel_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (st_q == S_IDLE && req) begin
                mode_cur <= mode_now;
                idx_q    <= '0;
                rd_sel_q <= 1'b0;
            end
            if (take_ack) begin
                idx_q <= idx_q + LEN_W'(1);
                if (mode_cur == IM_TABLE) begin
                    vec_hi_q <= base_reg;
                    vec_lo_q <= {din[7:1], 1'b0};
                end else if (idx_q == '0) begin
                    kind_q <= info.kind;
                    len_q  <= info.len;
                    push_q <= info.push;
                    rvec_q <= din[5:3];
                end
            end
            if (take_rd) begin
                if (!rd_sel_q) begin
                    tlo_q    <= din;
                    rd_sel_q <= 1'b1;
                end else begin
                    thi_q <= din;
                end
            end
        end
    end

    // operand bytes following the opcode
    for (genvar g = 0; g < OPND_BYTES; g++) begin : g_opnd
        always_ff @(posedge clk) begin
            if (rst) begin
                opnd_q[g] <= '0;
            end else if (take_ack && mode_cur == IM_FETCH &&
                         idx_q == LEN_W'(g + 1)) begin
                opnd_q[g] <= din;
            end
        end
    end

    logic [15:0] tgt_raw;
    always_comb begin
        unique case (mode_cur)
            IM_FIXED: tgt_raw = FIXED_ADDR;
            IM_TABLE: tgt_raw = {thi_q, tlo_q};
            default: begin
                unique case (kind_q)
                    K_RST:         tgt_raw = {10'd0, rvec_q, 3'd0};
                    K_CALL, K_JMP: tgt_raw = {opnd_q[1], opnd_q[0]};
                    default:       tgt_raw = 16'h0000;
                endcase
            end
        endcase
    end

    assign ack       = (st_q == S_ACK);
    assign rd_strb   = (st_q == S_RD);
    assign push_pc   = (st_q == S_PUSH);
    assign done      = (st_q == S_DONE);
    assign rd_addr   = rd_strb ? {vec_hi_q, vec_lo_q[7:1], rd_sel_q} : 16'h0000;
    assign target    = done ? tgt_raw : 16'h0000;
    assign push_flag = done && ((mode_cur == IM_FETCH) ? push_q : 1'b1);
endmodule

// File: rtl/intack_seq_chk.sv
module intack_seq_chk (
    input logic        clk,
    input logic        rst,
    input logic        ack,
    input logic        wait_ins,
    input logic        rd_strb,
    input logic [15:0] rd_addr,
    input logic        push_pc,
    input logic        done,
    input logic        ext_wait,
    input logic [15:0] target,
    input logic        push_flag
);
    a_r3_waits_need_ack: assert property (@(posedge clk) disable iff (rst)
        wait_ins |-> ack);

    a_r3_two_waits: assert property (@(posedge clk) disable iff (rst)
        $rose(wait_ins) |=> wait_ins ##1 !wait_ins);

    a_r9_push_then_even_read: assert property (@(posedge clk) disable iff (rst)
        push_pc |=> (rd_strb && !rd_addr[0]));

    a_r10_ack_held: assert property (@(posedge clk) disable iff (rst)
        (ack && !wait_ins && ext_wait) |=> ack);

    a_r10_read_held: assert property (@(posedge clk) disable iff (rst)
        (rd_strb && ext_wait) |=> (rd_strb && $stable(rd_addr)));

    a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r11_done_quiet: assert property (@(posedge clk) disable iff (rst)
        done |-> !(ack || rd_strb || push_pc));

    a_r11_flags_idle: assert property (@(posedge clk) disable iff (rst)
        !done |-> (target == 16'h0000 && !push_flag));
endmodule

bind intack_seq intack_seq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .ack       (ack),
    .wait_ins  (wait_ins),
    .rd_strb   (rd_strb),
    .rd_addr   (rd_addr),
    .push_pc   (push_pc),
    .done      (done),
    .ext_wait  (ext_wait),
    .target    (target),
    .push_flag (push_flag)
);

// File: tb/intack_seq_test.sv
`timescale 1ns/1ps
module intack_seq_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mode_wr = 1'b0;
    logic [1:0]  mode_val = 2'd0;
    logic        req = 1'b0;
    logic [7:0]  base_reg = 8'h00;
    logic [7:0]  din = 8'h00;
    logic        ext_wait = 1'b0;
    logic        ack, wait_ins, rd_strb, push_pc, done, push_flag;
    logic [15:0] rd_addr, target;

    always #2 clk = ~clk;

    intack_seq uut (
        .clk(clk), .rst(rst), .mode_wr(mode_wr), .mode_val(mode_val),
        .req(req), .base_reg(base_reg), .din(din), .ext_wait(ext_wait),
        .ack(ack), .wait_ins(wait_ins), .rd_strb(rd_strb), .rd_addr(rd_addr),
        .push_pc(push_pc), .done(done), .target(target), .push_flag(push_flag)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    int n_ack, n_rd, n_wait, n_push, n_done, done_at, n_strb;
    int ack_len [8];
    int rd_len  [8];
    int rd_a    [8];
    int got_t, got_p;
    logic [7:0] feed [4];

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected<=20000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic set_mode(input logic [1:0] m);
        @(negedge clk);
        mode_wr  = 1'b1;
        mode_val = m;
        @(negedge clk);
        mode_wr  = 1'b0;
    endtask

    // accept one sequence, then watch 40 clocks acting as the bus
    task automatic run_seq(input int hold, input int rereq_at);
        int hold_left = 0;
        logic p_ack = 1'b0, p_rd = 1'b0, p_any = 1'b0;
        n_ack = 0; n_rd = 0; n_wait = 0; n_push = 0; n_done = 0;
        done_at = -1; n_strb = 0; got_t = -1; got_p = -1;
        for (int i = 0; i < 8; i++) begin
            ack_len[i] = 0; rd_len[i] = 0; rd_a[i] = 0;
        end
        @(negedge clk);
        req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        for (int c = 0; c < 40; c++) begin
            req = (c == rereq_at);
            if ((ack || rd_strb) && !p_any) begin
                n_strb++;
                hold_left = hold;
            end
            if (ack && !p_ack) n_ack++;
            if (rd_strb && !p_rd) begin
                if (n_rd < 8) rd_a[n_rd] = int'(rd_addr);
                n_rd++;
            end
            if (ack && n_ack >= 1 && n_ack <= 8) ack_len[n_ack-1]++;
            if (rd_strb && n_rd >= 1 && n_rd <= 8) rd_len[n_rd-1]++;
            if (wait_ins) n_wait++;
            if (push_pc) n_push++;
            if (done) begin
                n_done++;
                got_t = int'(target);
                got_p = int'(push_flag);
                if (done_at < 0) done_at = c;
            end
            if (n_strb >= 1 && n_strb <= 4) din = feed[n_strb-1];
            if ((ack || rd_strb) && !wait_ins && hold_left > 0) begin
                ext_wait = 1'b1;
                hold_left--;
            end else begin
                ext_wait = 1'b0;
            end
            p_ack = ack; p_rd = rd_strb; p_any = ack || rd_strb;
            @(negedge clk);
        end
        req = 1'b0;
        ext_wait = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 ack in reset", int'(ack), 0);
        chk("R1 done in reset", int'(done), 0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 strobes idle after reset",
            int'({ack, wait_ins, rd_strb, push_pc, done}), 0);
    endtask

    task automatic t_restart;
        feed = '{8'hEF, 8'h00, 8'h00, 8'h00};
        run_seq(0, -1);
        chk("R2 default mode fetch, one strobe", n_ack, 1);
        chk("R4 restart target", got_t, 16'h0028);
        chk("R4 restart push", got_p, 1);
        chk("R3 first strobe length", ack_len[0], 3);
        chk("R3 inserted waits", n_wait, 2);
        chk("R11 single done", n_done, 1);
        chk("R11 done clock", done_at, 3);
    endtask

    task automatic t_call;
        feed = '{8'hCD, 8'h34, 8'h12, 8'h00};
        run_seq(0, -1);
        chk("R5 call strobes", n_ack, 3);
        chk("R5 call target", got_t, 16'h1234);
        chk("R5 call push", got_p, 1);
        chk("R3 strobe 1 length", ack_len[0], 3);
        chk("R3 strobe 2 length", ack_len[1], 1);
        chk("R3 strobe 3 length", ack_len[2], 1);
        chk("R3 waits only first", n_wait, 2);
        chk("R3 done clock", done_at, 7);
    endtask

    task automatic t_jump;
        feed = '{8'hC3, 8'h78, 8'h56, 8'h00};
        run_seq(0, -1);
        chk("R6 jump strobes", n_ack, 3);
        chk("R6 jump target", got_t, 16'h5678);
        chk("R6 jump no push", got_p, 0);
    endtask

    task automatic t_other;
        feed = '{8'h00, 8'h11, 8'h22, 8'h33};
        run_seq(0, -1);
        chk("R7 other strobes", n_ack, 1);
        chk("R7 other target", got_t, 0);
        chk("R7 other no push", got_p, 0);
    endtask

    task automatic t_busy;
        feed = '{8'hCD, 8'hAA, 8'hBB, 8'h00};
        run_seq(0, 4);
        chk("R12 one done", n_done, 1);
        chk("R12 strobes", n_ack, 3);
        chk("R12 target", got_t, 16'hBBAA);
    endtask

    task automatic t_fetch_stall;
        feed = '{8'hCD, 8'h11, 8'h22, 8'h00};
        run_seq(2, -1);
        chk("R10 stretched first", ack_len[0], 5);
        chk("R10 stretched second", ack_len[1], 3);
        chk("R10 stretched third", ack_len[2], 3);
        chk("R10 inserted waits", n_wait, 2);
        chk("R10 target", got_t, 16'h2211);
    endtask

    task automatic t_fixed;
        set_mode(2'd1);
        feed = '{8'hFF, 8'hFF, 8'hFF, 8'hFF};
        run_seq(0, -1);
        chk("R8 no ack", n_ack, 0);
        chk("R8 no read", n_rd, 0);
        chk("R8 done clock", done_at, 0);
        chk("R8 target", got_t, 16'h0038);
        chk("R8 push", got_p, 1);
    endtask

    task automatic t_table;
        set_mode(2'd2);
        base_reg = 8'h80;
        feed = '{8'h47, 8'h34, 8'h12, 8'h00};
        run_seq(0, -1);
        chk("R9 one ack", n_ack, 1);
        chk("R9 ack length", ack_len[0], 1);
        chk("R9 no inserted waits", n_wait, 0);
        chk("R9 push pulse", n_push, 1);
        chk("R9 two reads", n_rd, 2);
        chk("R9 first address", rd_a[0], 16'h8046);
        chk("R9 second address", rd_a[1], 16'h8047);
        chk("R9 target", got_t, 16'h1234);
        chk("R9 push flag", got_p, 1);
    endtask

    task automatic t_table_stall;
        base_reg = 8'h3C;
        feed = '{8'h91, 8'hEF, 8'hBE, 8'h00};
        run_seq(1, -1);
        chk("R10 ack stretched", ack_len[0], 2);
        chk("R10 read 1 stretched", rd_len[0], 2);
        chk("R10 read 2 stretched", rd_len[1], 2);
        chk("R10 read address", rd_a[0], 16'h3C90);
        chk("R10 table target", got_t, 16'hBEEF);
    endtask

    task automatic t_bad_mode;
        set_mode(2'd3);
        base_reg = 8'h10;
        feed = '{8'h02, 8'h11, 8'h22, 8'h00};
        run_seq(0, -1);
        chk("R2 mode 3 ignored, reads", n_rd, 2);
        chk("R2 mode 3 ignored, address", rd_a[0], 16'h1002);
        chk("R2 mode 3 ignored, target", got_t, 16'h2211);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_restart();
        t_call();
        t_jump();
        t_other();
        t_busy();
        t_fetch_stall();
        t_fixed();
        t_table();
        t_table_stall();
        t_bad_mode();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule